// File: doc/BRIEF.md
# Power-Up Start Sequencer with Supply and Reference Lockout

This block decides when a switching controller may run. It receives comparator outputs from the analog front end, already in digital form. Two of them report the supply crossing its start and stop levels. Two report the internal reference crossing its rise and fall levels. A fifth input is a one-cycle oscillator tick. Each pair of flags feeds its own registered hysteresis stage. The supply stage must be good before the reference stage can become good.

Once the reference is good, the block counts oscillator ticks. On the last tick of a fixed count, `run_en` is raised. Start-up is therefore deliberately slow, but shutdown is not. Any stop or fall flag drops `run_en` at the next clock edge, with no counting.

`ss_discharge` holds the soft-start capacitor empty whenever the controller is not running. It is raised again at every shutdown. Everything is registered on the clock that carries the oscillator tick as an enable, so both outputs change only at clock edges.

Top module: `pwr_start_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, `run_en` is 0 and `ss_discharge` is 1.
- R2: Supply-good is set one cycle after `sup_above_start` is 1. It stays set while neither supply flag is 1, and clears one cycle after `sup_below_stop` is 1. Operation needs supply-good.
- R3: Reference-good is set one cycle after `ref_above_rise` is 1, but only if supply-good was already set in that cycle. It stays set while neither reference flag is 1. It clears one cycle after `ref_below_fall` or `sup_below_stop` is 1, or whenever supply-good is clear.
- R4: Ticks are counted at clock edges where reference-good is already set. `run_en` rises one cycle after the edge at which the START_TICKS-th counted tick (default 32) is seen.
- R5: Ticks seen while reference-good is clear are not counted. A loss of reference-good during the count restarts the count from zero.
- R6: One cycle after `ref_below_fall` or `sup_below_stop` is 1, `run_en` is 0, whether or not a tick is present.
- R7: `ss_discharge` is always the complement of `run_en`.
- R8: If a stop or fall flag coincides with the completing tick, shutdown wins and `run_en` stays 0.
- R9: At the default CLEAR_WINS=1, a stage whose set and clear flags are both 1 in one cycle is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `osc_tick` is an enable on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_above_start | input | 1 | Supply is above the start threshold |
| sup_below_stop | input | 1 | Supply is below the shutdown threshold |
| ref_above_rise | input | 1 | Reference is above its rising threshold |
| ref_below_fall | input | 1 | Reference is below its falling threshold |
| osc_tick | input | 1 | One-cycle oscillator count pulse |
| run_en | output | 1 | Controller run enable, registered |
| ss_discharge | output | 1 | Soft-start discharge request, registered |

## Verification
Two events can land in the same cycle: the tick that completes the start-up count, and a stop or fall flag that shuts the block down.

The bench provokes this directly. It counts START_TICKS-1 ticks, then drives the last tick together with `ref_below_fall`. It expects `run_en` to stay low.

Set and clear flags arriving together are provoked both directly and throughout a long random phase. Every cycle of the random phase is compared against a next-state function written from the requirements.

// File: rtl/pwr_start_seq_pkg.sv
package pwr_start_seq_pkg;

   typedef struct packed {
      logic supply_ok;
      logic ref_good;
      logic run;
   } seq_state_t;

   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/hyst_flag.sv
module hyst_flag #(
   parameter bit CLEAR_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   logic q_nxt;

   generate
      if (CLEAR_WINS) begin : g_clear_dominant
         always_comb begin
            if (clr_i)      q_nxt = 1'b0;
            else if (set_i) q_nxt = 1'b1;
            else            q_nxt = q_o;
         end
      end else begin : g_set_dominant
         always_comb begin
            if (set_i)      q_nxt = 1'b1;
            else if (clr_i) q_nxt = 1'b0;
            else            q_nxt = q_o;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_nxt;
   end

   // Both outcomes hold for either dominance when only one flag is active.
   assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);
   assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i && !clr_i) |=> q_o);
   assert_flag_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i && !clr_i) |=> (q_o == $past(q_o)));
   generate
      if (CLEAR_WINS) begin : g_chk_clear
         assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i && clr_i) |=> !q_o);
      end
   endgenerate

endmodule

// File: rtl/start_tick_counter.sv
module start_tick_counter #(
   parameter int START_TICKS = 32,
   parameter int CNT_W       = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear_i,
   input  logic tick_i,
   output logic done_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(START_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   assign done_o = tick_i && !clear_i && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (clear_i) cnt_q <= '0;
      else if (tick_i)  cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
   end

   assert_cnt_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (cnt_q == '0));
   assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !clear_i && cnt_q != LAST) |=> (cnt_q == $past(cnt_q) + 1'b1));
   assert_cnt_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwr_start_seq.sv
module pwr_start_seq
   import pwr_start_seq_pkg::*;
#(
   parameter int START_TICKS = 32,
   parameter bit CLEAR_WINS  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_above_start,
   input  logic sup_below_stop,
   input  logic ref_above_rise,
   input  logic ref_below_fall,
   input  logic osc_tick,
   output logic run_en,
   output logic ss_discharge
);

   localparam int CNT_W = cnt_width(START_TICKS);

   generate
      if (START_TICKS < 2) begin : g_bad_ticks
         $error("pwr_start_seq: START_TICKS must be at least 2");
      end
   endgenerate

   seq_state_t st;
   logic       shut_req;
   logic       ref_clr;
   logic       cnt_clear;
   logic       cnt_done;
   logic       run_nxt;
   logic       dis_q;

   assign shut_req = ref_below_fall | sup_below_stop;
   assign ref_clr  = shut_req | ~st.supply_ok;

   hyst_flag #(.CLEAR_WINS(CLEAR_WINS)) u_supply_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sup_above_start),
      .clr_i (sup_below_stop),
      .q_o   (st.supply_ok)
   );

   hyst_flag #(.CLEAR_WINS(CLEAR_WINS)) u_ref_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ref_above_rise),
      .clr_i (ref_clr),
      .q_o   (st.ref_good)
   );

   assign cnt_clear = shut_req | ~st.ref_good | st.run;

   start_tick_counter #(.START_TICKS(START_TICKS), .CNT_W(CNT_W)) u_start_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (cnt_clear),
      .tick_i  (osc_tick),
      .done_o  (cnt_done)
   );

   always_comb begin
      if (shut_req || !st.ref_good) run_nxt = 1'b0;
      else                          run_nxt = st.run | cnt_done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st.run <= 1'b0;
         dis_q  <= 1'b1;
      end else begin
         st.run <= run_nxt;
         dis_q  <= ~run_nxt;
      end
   end

   assign run_en       = st.run;
   assign ss_discharge = dis_q;

   assert_shutdown_now_R6: assert property (@(posedge clk) disable iff (!rst_n)
      shut_req |=> !run_en);
   assert_run_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_en) |-> $past(osc_tick));
   assert_run_needs_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_en |-> (st.ref_good && st.supply_ok));
   assert_discharge_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ss_discharge != run_en);
   assert_no_run_on_lockout_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !st.supply_ok |=> !run_en);

endmodule

// File: tb/pwr_start_seq_bench.sv
module pwr_start_seq_bench;

   localparam int CLK_PERIOD  = 10;
   localparam int START_TICKS = 32;
   localparam int WATCHDOG    = 100000;

   typedef struct {
      bit sup;
      bit rf;
      bit run;
      int cnt;
   } mstate_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sa = 1'b0, sb = 1'b0, ra = 1'b0, rb = 1'b0, tk = 1'b0;
   logic run_en, ss_discharge;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit finished = 1'b0;
   mstate_t m;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwr_start_seq #(.START_TICKS(START_TICKS), .CLEAR_WINS(1'b1)) u_pwr_start_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .sup_above_start (sa),
      .sup_below_stop  (sb),
      .ref_above_rise  (ra),
      .ref_below_fall  (rb),
      .osc_tick        (tk),
      .run_en          (run_en),
      .ss_discharge    (ss_discharge)
   );

   // Next state from the requirements (R2..R9).
   function automatic mstate_t nxt(mstate_t s, bit a_sa, bit a_sb, bit a_ra, bit a_rb, bit a_tk);
      mstate_t n;
      bit shut = a_sb | a_rb;
      bit done = s.rf && !s.run && !shut && a_tk && (s.cnt == START_TICKS - 1);
      n.sup = a_sb ? 1'b0 : (a_sa ? 1'b1 : s.sup);
      n.rf  = (shut || !s.sup) ? 1'b0 : (a_ra ? 1'b1 : s.rf);
      n.run = (shut || !s.rf) ? 1'b0 : (s.run || done);
      if (shut || !s.rf || s.run) n.cnt = 0;
      else if (a_tk)              n.cnt = (s.cnt == START_TICKS - 1) ? 0 : s.cnt + 1;
      else                        n.cnt = s.cnt;
      return n;
   endfunction

   task automatic chk(input logic act, input logic exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
      end
   endtask

   task automatic step(input bit a_sa, input bit a_sb, input bit a_ra, input bit a_rb,
                       input bit a_tk, input string tag);
      sa = a_sa; sb = a_sb; ra = a_ra; rb = a_rb; tk = a_tk;
      @(posedge clk);
      m = nxt(m, a_sa, a_sb, a_ra, a_rb, a_tk);
      @(negedge clk);
      chk(run_en, m.run, {tag, " run_en"});
      chk(ss_discharge, !m.run, {"R7 ", tag, " ss_discharge"});
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, tag);
   endtask

   task automatic power_up(input string tag);
      step(1, 0, 0, 0, 0, tag);
      step(0, 0, 1, 0, 0, tag);
   endtask

   initial begin
      while (!finished) begin
         @(posedge clk);
         cycles++;
         if (cycles > WATCHDOG) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
         end
      end
   end

   initial begin
      int seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      m = '{sup: 0, rf: 0, run: 0, cnt: 0};

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(run_en, 1'b0, "R1 run_en in reset");
      chk(ss_discharge, 1'b1, "R1 ss_discharge in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(run_en, 1'b0, "R1 run_en after reset");
      chk(ss_discharge, 1'b1, "R1 ss_discharge after reset");

      // R3: reference rise ignored while supply is locked out
      for (int i = 0; i < 40; i++) step(0, 0, 1, 0, 1, "R3 rise without supply");
      chk(run_en, 1'b0, "R3 no run without supply");

      // R5: ticks before reference-good are not counted
      step(1, 0, 0, 0, 0, "R2 supply set");
      for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 1, "R5 ticks before ref good");
      step(0, 0, 1, 0, 0, "R3 ref set");
      // R4: exactly START_TICKS ticks to start
      for (int i = 0; i < START_TICKS - 1; i++) begin
         step(0, 0, 0, 0, 1, "R4 counting");
         idle(i % 3, "R4 gaps");
      end
      chk(run_en, 1'b0, "R4 not yet running before last tick");
      step(0, 0, 0, 0, 1, "R4 last tick");
      chk(run_en, 1'b1, "R4 running after last tick");

      // R2/R3: hysteresis holds with both set flags removed
      idle(20, "R2 R3 hold");
      chk(run_en, 1'b1, "R2 R3 run held");

      // R6: immediate shutdown, no tick
      step(0, 0, 0, 1, 0, "R6 ref fall");
      chk(run_en, 1'b0, "R6 run dropped");
      chk(ss_discharge, 1'b1, "R7 discharge reasserted");

      // R5: partial count lost on a reference drop
      step(0, 0, 1, 0, 0, "R3 ref set again");
      for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, "R5 partial");
      step(0, 0, 0, 1, 0, "R5 ref drop");
      step(0, 0, 1, 0, 0, "R5 ref back");
      for (int i = 0; i < START_TICKS - 1; i++) step(0, 0, 0, 0, 1, "R5 recount");
      chk(run_en, 1'b0, "R5 count restarted");
      step(0, 0, 0, 0, 1, "R5 final tick");
      chk(run_en, 1'b1, "R5 run after full recount");

      // R6: supply stop also shuts down at once
      step(0, 1, 0, 0, 1, "R6 supply stop");
      chk(run_en, 1'b0, "R6 supply stop dropped run");

      // R9: set and clear together -> clear
      step(1, 1, 0, 0, 0, "R9 supply both flags");
      step(0, 0, 1, 0, 0, "R9 rise after cleared supply");
      for (int i = 0; i < START_TICKS + 2; i++) step(0, 0, 0, 0, 1, "R9 no start");
      chk(run_en, 1'b0, "R9 supply stage cleared");
      power_up("R9 power up");
      step(0, 0, 1, 1, 0, "R9 ref both flags");
      for (int i = 0; i < START_TICKS + 2; i++) step(0, 0, 0, 0, 1, "R9 ref no start");
      chk(run_en, 1'b0, "R9 ref stage cleared");

      // R8: shutdown coincides with the completing tick
      step(0, 0, 1, 0, 0, "R8 ref set");
      for (int i = 0; i < START_TICKS - 1; i++) step(0, 0, 0, 0, 1, "R8 count");
      step(0, 0, 0, 1, 1, "R8 tick with fall");
      chk(run_en, 1'b0, "R8 shutdown wins");
      idle(3, "R8 after");
      chk(run_en, 1'b0, "R8 still stopped");

      // Random phase: all requirements against the model
      for (int i = 0; i < 6000; i++) begin
         bit r_sa = ($urandom_range(99) < 30);
         bit r_sb = ($urandom_range(999) < 8);
         bit r_ra = ($urandom_range(99) < 30);
         bit r_rb = ($urandom_range(999) < 12);
         bit r_tk = ($urandom_range(99) < 45);
         step(r_sa, r_sb, r_ra, r_rb, r_tk, "R2 R3 R4 R5 R6 R8 R9 random");
      end

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule